// File: doc/BRIEF.md
# I2C Master Clock Pulse Generator

This block produces the clock line waveform for a local I2C master. The high and low widths of the clock are set separately by two 8-bit fields. Each field counts base ticks, and one tick is `TICK_DIV` clock cycles, which is 50 ns at the nominal clock. The block never drives the line high. It only pulls it low, and during the high part it watches the real line level. A slave that stretches the clock therefore lengthens the period instead of being cut short. A one-cycle strobe marks the first cycle of every low and every high phase, so the protocol engine can step its data and sampling in time with the clock.

The low-width field has a second use. A slave-side bridge that is holding the clock low pulses a start input. The block then times the same low width on a separate timer and returns a done strobe. The bridge releases the clock on that strobe, which gives the data line a setup time equal to the master low width. Both fields would normally be reset to 0x82 by their register. That value gives at least 5 µs per phase when the oscillator runs fast at 26 MHz instead of 20 MHz.

Top module: `i2c_scl_timer`

## Requirements
- R1: While reset is asserted, and for the cycles after its release until a run request is seen, `scl_drive_low_o`, `phase_stb_o` and `setup_done_o` are all 0.
- R2: Each low phase holds `scl_drive_low_o` at 1 for exactly N*`TICK_DIV` consecutive cycles. N is the value of `low_ticks_i` sampled at the clock edge that starts the phase.
- R3: After a low phase with run requested, the line is released and the high count starts only at the clock edge after `scl_line_i` is seen high. The high phase then lasts exactly N*`TICK_DIV` cycles, where N is `high_ticks_i` sampled at that edge. A line held low by a slave delays the high strobe by one cycle per held cycle.
- R4: A field value of 0 gives a phase of one tick (`TICK_DIV` cycles), for both widths and for the setup timer.
- R5: `phase_stb_o` is 1 for exactly the first cycle of every low phase and every high phase, and is 0 at all other times.
- R6: If the run request is low at the clock edge that ends the current phase, the line is left released and no further low phase starts while run stays low. The phase in progress still runs its full width. Raising run again starts a low phase at the next clock edge.
- R7: A change of either field in the middle of a phase has no effect on that phase's width.
- R8: When `setup_start_i` is sampled 1, `setup_done_o` pulses for one cycle exactly N*`TICK_DIV` cycles later, with N taken from `low_ticks_i` at that edge. A new start while the timer is running restarts the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| run_i | input | 1 | Request to keep generating clock periods |
| high_ticks_i | input | 8 | Clock high width in base ticks (0 treated as 1) |
| low_ticks_i | input | 8 | Clock low width and slave setup time in base ticks (0 treated as 1) |
| scl_line_i | input | 1 | Observed clock line level, already synchronised |
| setup_start_i | input | 1 | Slave-side request to begin timing a setup interval |
| scl_drive_low_o | output | 1 | 1 pulls the clock line low, 0 releases it |
| phase_stb_o | output | 1 | One-cycle strobe in the first cycle of each low and high phase |
| setup_done_o | output | 1 | One-cycle strobe when the setup interval has elapsed |

## Verification
Random pairs of widths, including zero and the full-scale value, show whether the two fields map to the right phases and whether the tick scaling is exact. A random stretch length on every release separates a high count that waits for the line from one that starts blindly. Each field is overwritten with junk just after its phase begins, which exposes a design that reads the field live instead of latching it. Directed cases drop the run request during a low phase and during a high phase, and start the setup timer alone and again in the middle of a count.

// File: rtl/scl_pkg.sv
package scl_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOW  = 2'd1,
    ST_WAIT = 2'd2,
    ST_HIGH = 2'd3
  } scl_state_e;

  localparam int unsigned NUM_TIMERS = 2;
  localparam int unsigned TMR_MASTER = 0;
  localparam int unsigned TMR_SETUP  = 1;

endpackage

// File: rtl/scl_rst_sync.sv
module scl_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/scl_span_timer.sv
module scl_span_timer #(
  parameter int unsigned TICK_DIV = 10,
  parameter int unsigned FIELD_W  = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load_i,
  input  logic [FIELD_W-1:0] ticks_i,
  output logic               done_o
);

  localparam int unsigned SUB_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [SUB_W-1:0]   SUB_TOP = SUB_W'(TICK_DIV - 1);
  localparam logic [FIELD_W-1:0] ONE     = FIELD_W'(1);

  logic [SUB_W-1:0]   sub_q, sub_d;
  logic [FIELD_W-1:0] rem_q, rem_d;
  logic               busy_q, busy_d;
  logic               cnt_en;
  logic               sub_last;

  assign sub_last = (sub_q == '0);
  assign done_o   = busy_q && sub_last && (rem_q == ONE);
  assign cnt_en   = load_i || busy_q;

  always_comb begin
    sub_d  = sub_q;
    rem_d  = rem_q;
    busy_d = busy_q;
    if (load_i) begin
      sub_d  = SUB_TOP;
      rem_d  = (ticks_i == '0) ? ONE : ticks_i;
      busy_d = 1'b1;
    end else if (busy_q) begin
      if (sub_last) begin
        sub_d = SUB_TOP;
        if (rem_q == ONE) begin
          busy_d = 1'b0;
        end else begin
          rem_d = rem_q - ONE;
        end
      end else begin
        sub_d = sub_q - SUB_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sub_q  <= '0;
      rem_q  <= '0;
      busy_q <= 1'b0;
    end else if (cnt_en) begin
      sub_q  <= sub_d;
      rem_q  <= rem_d;
      busy_q <= busy_d;
    end
  end

endmodule

// File: rtl/i2c_scl_timer.sv
module i2c_scl_timer
  import scl_pkg::*;
#(
  parameter int unsigned TICK_DIV   = 10,
  parameter int unsigned FIELD_W    = 8,
  parameter int unsigned RST_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run_i,
  input  logic [FIELD_W-1:0] high_ticks_i,
  input  logic [FIELD_W-1:0] low_ticks_i,
  input  logic               scl_line_i,
  input  logic               setup_start_i,
  output logic               scl_drive_low_o,
  output logic               phase_stb_o,
  output logic               setup_done_o
);

  logic       rst_core_n;
  scl_state_e state_q, state_d;
  logic       stb_q, stb_d;
  logic       mst_load;
  logic       sel_high;

  logic               load_v  [NUM_TIMERS];
  logic [FIELD_W-1:0] ticks_v [NUM_TIMERS];
  logic               done_v  [NUM_TIMERS];

  scl_rst_sync #(.STAGES(RST_STAGES)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_core_n)
  );

  // Timer 0 times master phases, timer 1 times the slave-side setup interval.
  always_comb begin
    load_v[TMR_MASTER]  = mst_load;
    ticks_v[TMR_MASTER] = sel_high ? high_ticks_i : low_ticks_i;
    load_v[TMR_SETUP]   = setup_start_i;
    ticks_v[TMR_SETUP]  = low_ticks_i;
  end

  for (genvar g = 0; g < NUM_TIMERS; g++) begin : g_tmr
    scl_span_timer #(
      .TICK_DIV (TICK_DIV),
      .FIELD_W  (FIELD_W)
    ) u_tmr (
      .clk     (clk),
      .rst_n   (rst_core_n),
      .load_i  (load_v[g]),
      .ticks_i (ticks_v[g]),
      .done_o  (done_v[g])
    );
  end

  always_comb begin
    state_d  = state_q;
    stb_d    = 1'b0;
    mst_load = 1'b0;
    sel_high = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (run_i) begin
          state_d  = ST_LOW;
          mst_load = 1'b1;
          stb_d    = 1'b1;
        end
      end
      ST_LOW: begin
        if (done_v[TMR_MASTER]) begin
          state_d = run_i ? ST_WAIT : ST_IDLE;
        end
      end
      ST_WAIT: begin
        if (!run_i) begin
          state_d = ST_IDLE;
        end else if (scl_line_i) begin
          state_d  = ST_HIGH;
          mst_load = 1'b1;
          sel_high = 1'b1;
          stb_d    = 1'b1;
        end
      end
      ST_HIGH: begin
        if (done_v[TMR_MASTER]) begin
          if (run_i) begin
            state_d  = ST_LOW;
            mst_load = 1'b1;
            stb_d    = 1'b1;
          end else begin
            state_d = ST_IDLE;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      state_q <= ST_IDLE;
      stb_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      stb_q   <= stb_d;
    end
  end

  assign scl_drive_low_o = (state_q == ST_LOW);
  assign phase_stb_o     = stb_q;
  assign setup_done_o    = done_v[TMR_SETUP];

endmodule

// File: rtl/i2c_scl_timer_chk.sv
module i2c_scl_timer_chk #(
  parameter int unsigned TICK_DIV = 10,
  parameter int unsigned FIELD_W  = 8
) (
  input logic clk,
  input logic rst_n,
  input logic run_i,
  input logic scl_line_i,
  input logic scl_drive_low_o,
  input logic phase_stb_o
);

  localparam int unsigned LOW_LIMIT = (2 ** FIELD_W) * TICK_DIV;

  int unsigned low_run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_run_q <= 0;
    end else if (scl_drive_low_o) begin
      low_run_q <= low_run_q + 1;
    end else begin
      low_run_q <= 0;
    end
  end

  AST_LOW_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    scl_drive_low_o |-> (low_run_q < LOW_LIMIT)); // R2

  AST_HIGH_AFTER_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_stb_o && !scl_drive_low_o) |-> $past(scl_line_i)); // R3

  AST_LOW_HAS_STB: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scl_drive_low_o) |-> phase_stb_o); // R5

  AST_STB_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_stb_o && scl_drive_low_o) |-> $rose(scl_drive_low_o)); // R5

  AST_NO_START_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> !$rose(scl_drive_low_o)); // R6

endmodule

bind i2c_scl_timer i2c_scl_timer_chk #(
  .TICK_DIV (TICK_DIV),
  .FIELD_W  (FIELD_W)
) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .run_i           (run_i),
  .scl_line_i      (scl_line_i),
  .scl_drive_low_o (scl_drive_low_o),
  .phase_stb_o     (phase_stb_o)
);

// File: tb/i2c_scl_timer_tb.sv
module i2c_scl_timer_tb;

  localparam int D = 4;

  logic       clk;
  logic       rst_n;
  logic       run;
  logic [7:0] high_ticks;
  logic [7:0] low_ticks;
  logic       stretch;
  logic       setup_start;
  logic       drive_low;
  logic       phase_stb;
  logic       setup_done;
  logic       scl_line;

  int n_checks;
  int n_fail;

  assign scl_line = !drive_low && !stretch;

  i2c_scl_timer #(.TICK_DIV(D), .FIELD_W(8), .RST_STAGES(2)) u_dut (
    .clk             (clk),
    .rst_n           (rst_n),
    .run_i           (run),
    .high_ticks_i    (high_ticks),
    .low_ticks_i     (low_ticks),
    .scl_line_i      (scl_line),
    .setup_start_i   (setup_start),
    .scl_drive_low_o (drive_low),
    .phase_stb_o     (phase_stb),
    .setup_done_o    (setup_done)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic int eff(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog actual=1 expected=0");
    summary();
  end

  initial begin
    int cur_lo;
    int cnt;
    void'($urandom(32'h5C1A));
    n_checks = 0;
    n_fail = 0;
    rst_n = 1'b0;
    run = 1'b0;
    stretch = 1'b0;
    setup_start = 1'b0;
    high_ticks = 8'd0;
    low_ticks = 8'd0;
    repeat (3) @(negedge clk);
    chk(!drive_low && !phase_stb && !setup_done, "R1 in reset", drive_low, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!drive_low && !phase_stb && !setup_done, "R1 after release", drive_low, 0);

    // Random periods with stretch and mid-phase field scrambling
    cur_lo = 5;
    low_ticks = 8'(cur_lo);
    run = 1'b1;
    do @(negedge clk); while (!(phase_stb && drive_low));
    for (int i = 0; i < 24; i++) begin
      int hi;
      int nlo;
      int st;
      hi  = (i == 0) ? 0 : (i == 1) ? 255 : (i == 2) ? 1 : int'($urandom % 48);
      nlo = (i == 0) ? 0 : (i == 1) ? 255 : int'($urandom % 48);
      st  = (i < 3) ? 0 : int'($urandom % 6);
      high_ticks = 8'(hi);
      low_ticks  = 8'($urandom % 256); // R7 scramble during low
      cnt = 1;
      @(negedge clk);
      while (drive_low) begin
        cnt++;
        @(negedge clk);
      end
      chk(cnt == eff(cur_lo) * D, "R2/R4/R7 low width", cnt, eff(cur_lo) * D);
      chk(!phase_stb, "R5 no strobe on release", phase_stb, 0);
      stretch = (st > 0);
      for (int k = 0; k < st; k++) begin
        @(negedge clk);
        chk(!phase_stb && !drive_low, "R3 held during stretch", phase_stb, 0);
      end
      stretch = 1'b0;
      @(negedge clk);
      chk(phase_stb && !drive_low, "R3/R5 high strobe after line", phase_stb, 1);
      low_ticks  = 8'(nlo);
      high_ticks = 8'($urandom % 256); // R7 scramble during high
      cnt = 1;
      @(negedge clk);
      while (!drive_low) begin
        cnt++;
        @(negedge clk);
      end
      chk(cnt == eff(hi) * D, "R3/R4/R7 high width", cnt, eff(hi) * D);
      chk(phase_stb, "R5 low strobe", phase_stb, 1);
      cur_lo = nlo;
    end

    // R6: run drops during a low phase
    run = 1'b0;
    cnt = 1;
    @(negedge clk);
    while (drive_low) begin
      cnt++;
      @(negedge clk);
    end
    chk(cnt == eff(cur_lo) * D, "R6 low completes", cnt, eff(cur_lo) * D);
    cnt = 0;
    for (int k = 0; k < 300; k++) begin
      if (drive_low || phase_stb) cnt++;
      @(negedge clk);
    end
    chk(cnt == 0, "R6 stays released after low", cnt, 0);
    low_ticks = 8'd3;
    high_ticks = 8'd2;
    run = 1'b1;
    @(negedge clk);
    chk(drive_low && phase_stb, "R6 restart on run", drive_low, 1);
    do @(negedge clk); while (drive_low);
    do @(negedge clk); while (!phase_stb);
    // R6: run drops during a high phase
    run = 1'b0;
    cnt = 1;
    for (int k = 0; k < 300; k++) begin
      @(negedge clk);
      if (!drive_low && k < 2 * D - 1) cnt++;
      if (drive_low || (phase_stb && k > 0)) cnt = 1000;
    end
    chk(cnt == 2 * D, "R6 high completes then idle", cnt, 2 * D);

    // R8: setup timer, with zero, mid and full-scale values
    for (int j = 0; j < 3; j++) begin
      int l;
      l = (j == 0) ? 0 : (j == 1) ? 7 : 255;
      low_ticks = 8'(l);
      setup_start = 1'b1;
      @(negedge clk);
      setup_start = 1'b0;
      low_ticks = 8'($urandom % 256);
      cnt = 1;
      while (!setup_done && cnt < 3000) begin
        @(negedge clk);
        cnt++;
      end
      chk(cnt == eff(l) * D, "R8/R4 setup interval", cnt, eff(l) * D);
      @(negedge clk);
      chk(!setup_done, "R8 single pulse", setup_done, 0);
      repeat (3) @(negedge clk);
    end
    // R8 restart
    low_ticks = 8'd10;
    setup_start = 1'b1;
    @(negedge clk);
    setup_start = 1'b0;
    cnt = 0;
    repeat (5) begin
      if (setup_done) cnt++;
      @(negedge clk);
    end
    low_ticks = 8'd6;
    setup_start = 1'b1;
    @(negedge clk);
    setup_start = 1'b0;
    cnt = 1;
    while (!setup_done && cnt < 3000) begin
      @(negedge clk);
      cnt++;
    end
    chk(cnt == 6 * D, "R8 restart", cnt, 6 * D);
    chk(!drive_low && !phase_stb, "R6 setup leaves master idle", drive_low, 0);
    summary();
  end

endmodule